// File: doc/BRIEF.md
# Bus Clock-Master Line Supervisor

This block lives in the node that generates the clock on a single-wire, open-drain bus. The line idles high. The block samples the line once per clock cycle, and each cycle is one sample tick. One bit time spans `TICKS_PER_BIT` ticks. The raw line first passes through a two-stage synchroniser. A single run-length counter of consecutive low samples then serves three jobs.

While the bus clock is stopped, a low pulse of at least 1/64 bit time is a wake-up call. The block answers with a one-cycle request to start sending clock signs. While the bus runs, the master releases the line at the end of each bit. If some node holds the line low for 1/8 bit time or more from that release, a sticky reset flag is set. On request, the block measures the width, in ticks, of the next complete low pulse, which is the single zero bit returned by an addressed node. A phase correction is later computed from that width.

The surrounding logic supplies `bus_active_i`, which is high while the clock is running, and a `release_i` strobe in the tick where the master stops pulling low. Encoding, framing and the correction arithmetic are done elsewhere.

Top module: `bus_line_supervisor`

## Requirements
- R1: After reset, `start_clk_o`, `reset_flag_o` and `width_valid_o` are 0 and `width_o` is 0.
- R2: `line_i` and `release_i` each pass through two flops before any counting. On an idle bus, a low that is first sampled at clock edge e gives a `start_clk_o` pulse that is visible after edge e+3 (default WAKE_TICKS = 2).
- R3: While `bus_active_i` is 0, a synchronised low run reaching WAKE_TICKS = TICKS_PER_BIT/64 samples produces exactly one single-cycle `start_clk_o` pulse, however long the low lasts.
- R4: A low run shorter than WAKE_TICKS gives no start request. No start request is ever made for a sample taken while `bus_active_i` is 1.
- R5: While `bus_active_i` is 1, `reset_flag_o` is set if the line is low in the sample taken with `release_i` and stays low for LATE_TICKS = TICKS_PER_BIT/8 consecutive samples counted from that one.
- R6: A rise after fewer than LATE_TICKS low samples leaves `reset_flag_o` unchanged. The flag stays set until `clr_flag_i`. A set in the same cycle as a clear wins.
- R7: After `meas_req_i`, the number of low samples in the first low pulse whose falling edge is seen after the request is loaded into `width_o`. `width_valid_o` then goes to 1, and both hold until the next request.
- R8: `meas_req_i` clears `width_valid_o` at the next edge. A pulse already low at the request is skipped. A width above 2^CNT_W-1 saturates at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, one sample tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Raw bus line level (1 = released/high) |
| bus_active_i | input | 1 | 1 while the bus clock is being generated |
| release_i | input | 1 | Tick in which the master releases the line at bit end |
| clr_flag_i | input | 1 | Clears the reset-detected flag |
| meas_req_i | input | 1 | Arms a pulse-width measurement |
| start_clk_o | output | 1 | One-cycle request to begin clock sign transmission |
| reset_flag_o | output | 1 | Sticky reset-detected flag |
| width_valid_o | output | 1 | `width_o` holds a fresh measurement |
| width_o | output | CNT_W | Measured low-pulse width in ticks |

## Verification
The assertions check on every cycle that a start request lasts one cycle and never follows an active-bus sample, that the reset flag only rises while the bus is active and holds until cleared, and that a captured width stays stable until the next request, which clears its valid bit. Only the scenarios can show the exact thresholds. These are the one-sample glitch that must not wake the master, the 15-versus-16-sample late release, the two-stage latency, the skipping of a pulse already low at the request, and width saturation. The cycle-accurate reference model in the bench covers them all.

// File: rtl/bls_pkg.sv
package bls_pkg;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_WAIT = 2'd1,
    MS_RUN  = 2'd2
  } meas_state_t;

  // Wake-up threshold: 1/64 of a bit time, never below one sample
  function automatic int wake_ticks(input int tpb);
    return (tpb / 64 < 1) ? 1 : tpb / 64;
  endfunction

  // Late-rise threshold: 1/8 of a bit time, never below one sample
  function automatic int late_ticks(input int tpb);
    return (tpb / 8 < 1) ? 1 : tpb / 8;
  endfunction

endpackage

// File: rtl/bls_sync.sv
// Multi-stage synchroniser with a selectable reset level (R2)
module bls_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= d_i;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bls_run_counter.sv
// Counts consecutive synchronised low samples, saturating
module bls_run_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             low_i,
  output logic [CNT_W-1:0] run_o
);
  localparam logic [CNT_W-1:0] RUN_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)             run_o <= '0;
    else if (!low_i)        run_o <= '0;
    else if (run_o != RUN_MAX) run_o <= run_o + 1'b1;
  end
endmodule

// File: rtl/bls_late_detect.sv
// Counts low samples from the aligned release strobe; flags a late rise
module bls_late_detect #(
  parameter int CNT_W      = 8,
  parameter int LATE_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic rel_i,
  input  logic low_i,
  output logic hit_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LATE_V  = CNT_W'(LATE_TICKS);

  logic             track_q, track_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_comb begin
    track_n = 1'b0;
    cnt_n   = cnt_q;
    if (rel_i && low_i) begin
      track_n = 1'b1;
      cnt_n   = CNT_W'(1);
    end else if (track_q && low_i) begin
      track_n = 1'b1;
      cnt_n   = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    end
  end

  // R5: late-rise event
  assign hit_o = active_i && track_n && (cnt_n == LATE_V);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      track_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      track_q <= track_n;
      cnt_q   <= cnt_n;
    end
  end
endmodule

// File: rtl/bls_width_meas.sv
// Captures the width of the first full low pulse after a request
module bls_width_meas #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             low_i,
  input  logic [CNT_W-1:0] run_i,
  output logic [CNT_W-1:0] width_o,
  output logic             valid_o
);
  import bls_pkg::*;

  meas_state_t st_q;
  logic        fresh_fall;
  logic        pulse_end;

  assign fresh_fall = low_i && (run_i == '0);
  assign pulse_end  = (st_q == MS_RUN) && !low_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= MS_IDLE;
      width_o <= '0;
      valid_o <= 1'b0;
    end else if (req_i) begin
      st_q    <= MS_WAIT;
      valid_o <= 1'b0;
    end else begin
      case (st_q)
        MS_WAIT: if (fresh_fall) st_q <= MS_RUN;
        MS_RUN: if (pulse_end) begin
          width_o <= run_i;
          valid_o <= 1'b1;
          st_q    <= MS_IDLE;
        end
        default: st_q <= MS_IDLE;
      endcase
    end
  end

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !req_i) |=> (valid_o && $stable(width_o))); // R7
  AST_REQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    req_i |=> !valid_o); // R8
endmodule

// File: rtl/bus_line_supervisor.sv
module bus_line_supervisor #(
  parameter int TICKS_PER_BIT = 128,
  parameter int CNT_W         = 8,
  parameter int SYNC_STAGES   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_i,
  input  logic             bus_active_i,
  input  logic             release_i,
  input  logic             clr_flag_i,
  input  logic             meas_req_i,
  output logic             start_clk_o,
  output logic             reset_flag_o,
  output logic             width_valid_o,
  output logic [CNT_W-1:0] width_o
);
  import bls_pkg::*;

  localparam int WAKE_TICKS = wake_ticks(TICKS_PER_BIT);
  localparam int LATE_TICKS = late_ticks(TICKS_PER_BIT);
  localparam logic [CNT_W-1:0] WAKE_M1 = CNT_W'(WAKE_TICKS - 1);

  logic             line_s, rel_s, low_s;
  logic [CNT_W-1:0] run;
  logic             wake_hit, late_hit;

  // R2: line and release strobe share the same latency
  bls_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_line (
    .clk(clk), .rst_n(rst_n), .d_i(line_i), .q_o(line_s));
  bls_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_rel (
    .clk(clk), .rst_n(rst_n), .d_i(release_i), .q_o(rel_s));

  assign low_s = !line_s;

  bls_run_counter #(.CNT_W(CNT_W)) u_run (
    .clk(clk), .rst_n(rst_n), .low_i(low_s), .run_o(run));

  bls_late_detect #(.CNT_W(CNT_W), .LATE_TICKS(LATE_TICKS)) u_late (
    .clk(clk), .rst_n(rst_n), .active_i(bus_active_i), .rel_i(rel_s),
    .low_i(low_s), .hit_o(late_hit));

  bls_width_meas #(.CNT_W(CNT_W)) u_meas (
    .clk(clk), .rst_n(rst_n), .req_i(meas_req_i), .low_i(low_s),
    .run_i(run), .width_o(width_o), .valid_o(width_valid_o));

  // R3: the run passes the threshold exactly once per low pulse
  assign wake_hit = !bus_active_i && low_s && (run == WAKE_M1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_clk_o  <= 1'b0;
      reset_flag_o <= 1'b0;
    end else begin
      start_clk_o <= wake_hit;
      if (late_hit)        reset_flag_o <= 1'b1;
      else if (clr_flag_i) reset_flag_o <= 1'b0;
    end
  end

  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_clk_o |=> !start_clk_o); // R3
  AST_NO_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    start_clk_o |-> !$past(bus_active_i)); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (reset_flag_o && !clr_flag_i) |=> reset_flag_o); // R6
  AST_FLAG_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reset_flag_o) |-> $past(bus_active_i)); // R5
endmodule

// File: tb/tb_bus_line_supervisor.sv
module tb_bus_line_supervisor;
  localparam int CLK_P = 10;
  localparam int TPB   = 128;
  localparam int CW    = 8;
  localparam int WAKE  = TPB / 64;
  localparam int LATE  = TPB / 8;
  localparam int MAXW  = (1 << CW) - 1;

  logic clk = 0, rst_n = 0;
  logic line_i = 1, bus_active_i = 0, release_i = 0, clr_flag_i = 0, meas_req_i = 0;
  logic start_clk_o, reset_flag_o, width_valid_o;
  logic [CW-1:0] width_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int start_cnt = 0, start_cyc = -1, flag_seen = 0;

  bus_line_supervisor #(.TICKS_PER_BIT(TPB), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .line_i(line_i), .bus_active_i(bus_active_i),
    .release_i(release_i), .clr_flag_i(clr_flag_i), .meas_req_i(meas_req_i),
    .start_clk_o(start_clk_o), .reset_flag_o(reset_flag_o),
    .width_valid_o(width_valid_o), .width_o(width_o));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Behavioural reference model
  int lq[$], rq[$];
  int m_run = 0, m_start = 0, m_flag = 0, m_valid = 0, m_width = 0;
  int m_st = 0, m_tr = 0, m_lc = 0;   // m_st: 0 idle, 1 waiting for fall, 2 in pulse

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      lq.delete(); rq.delete();
      m_run = 0; m_start = 0; m_flag = 0; m_valid = 0; m_width = 0;
      m_st = 0; m_tr = 0; m_lc = 0;
    end else begin
      int ls, rl, lo, tr, lc, hit;
      ls = (lq.size() >= 2) ? lq[lq.size()-2] : 1;
      rl = (rq.size() >= 2) ? rq[rq.size()-2] : 0;
      lo = !ls;
      m_start = (!bus_active_i && lo && m_run == WAKE-1) ? 1 : 0;
      tr = 0; lc = m_lc;
      if (rl && lo) begin tr = 1; lc = 1; end
      else if (m_tr && lo) begin tr = 1; lc = (m_lc < MAXW) ? m_lc + 1 : m_lc; end
      hit = (bus_active_i && tr && lc == LATE) ? 1 : 0;
      m_tr = tr; m_lc = lc;
      if (hit) m_flag = 1; else if (clr_flag_i) m_flag = 0;
      if (meas_req_i) begin m_st = 1; m_valid = 0; end
      else if (m_st == 1 && lo && m_run == 0) m_st = 2;
      else if (m_st == 2 && !lo) begin m_width = m_run; m_valid = 1; m_st = 0; end
      m_run = lo ? ((m_run < MAXW) ? m_run + 1 : m_run) : 0;
      lq.push_back(int'(line_i)); rq.push_back(int'(release_i));
      if (lq.size() > 4) begin void'(lq.pop_front()); void'(rq.pop_front()); end
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 start_clk_o vs model", start_clk_o, m_start);
      chk("R5 reset_flag_o vs model", reset_flag_o, m_flag);
      chk("R7 width_valid_o vs model", width_valid_o, m_valid);
      chk("R7 width_o vs model", width_o, m_width);
      if (start_clk_o) begin start_cnt++; start_cyc = cyc; end
      if (reset_flag_o) flag_seen = 1;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic low_pulse(input int n);
    line_i = 0; wait_n(n); line_i = 1; wait_n(6);
  endtask

  // Active bit whose rise comes n samples after the release (n includes release tick)
  task automatic late_bit(input int n);
    line_i = 0; wait_n(20);
    release_i = 1; wait_n(1); release_i = 0;
    wait_n(n - 1); line_i = 1; wait_n(8);
  endtask

  initial begin
    int t0;
    wait_n(4); rst_n = 1; wait_n(1);
    chk("R1 start_clk_o after reset", start_clk_o, 0);
    chk("R1 reset_flag_o after reset", reset_flag_o, 0);
    chk("R1 width_valid_o after reset", width_valid_o, 0);
    chk("R1 width_o after reset", width_o, 0);

    // Idle bus: glitch shorter than threshold
    start_cnt = 0; low_pulse(WAKE - 1); wait_n(5);
    chk("R4 short idle low gives no start", start_cnt, 0);

    // Idle bus: exact-threshold pulse and its latency
    start_cnt = 0; t0 = cyc; low_pulse(WAKE); wait_n(5);
    chk("R3 threshold pulse gives one start", start_cnt, 1);
    chk("R2 start latency in edges", start_cyc - t0, 4);

    start_cnt = 0; low_pulse(40); wait_n(5);
    chk("R3 long low gives exactly one start", start_cnt, 1);

    // Active bus: no wake-up requests
    bus_active_i = 1; wait_n(2);
    start_cnt = 0; low_pulse(12); wait_n(5);
    chk("R4 no start while active", start_cnt, 0);

    // Late rise just below threshold
    late_bit(LATE - 1);
    chk("R6 rise after LATE-1 samples keeps flag clear", reset_flag_o, 0);
    late_bit(1);
    chk("R6 on-time rise keeps flag clear", reset_flag_o, 0);
    late_bit(LATE);
    chk("R5 rise after LATE samples sets flag", reset_flag_o, 1);
    wait_n(30); late_bit(3);
    chk("R6 flag is sticky", reset_flag_o, 1);
    clr_flag_i = 1; wait_n(1); clr_flag_i = 0; wait_n(1);
    chk("R6 clear input resets flag", reset_flag_o, 0);
    flag_seen = 0; clr_flag_i = 1; late_bit(LATE + 4); clr_flag_i = 0;
    chk("R6 set wins over simultaneous clear", flag_seen, 1);
    chk("R6 held clear removes flag afterwards", reset_flag_o, 0);

    // Measurement of one low bit
    meas_req_i = 1; wait_n(1); meas_req_i = 0; wait_n(3);
    low_pulse(37); wait_n(2);
    chk("R7 width captured", width_o, 37);
    chk("R7 valid after capture", width_valid_o, 1);
    low_pulse(9); wait_n(2);
    chk("R7 width held until next request", width_o, 37);

    // Request while the line is already low: that pulse is skipped
    line_i = 0; wait_n(5);
    meas_req_i = 1; wait_n(1); meas_req_i = 0;
    chk("R8 request clears valid", width_valid_o, 0);
    wait_n(10); line_i = 1; wait_n(6);
    chk("R8 pulse low at request not measured", width_valid_o, 0);
    low_pulse(20); wait_n(2);
    chk("R8 next full pulse measured", width_o, 20);

    // Saturation
    meas_req_i = 1; wait_n(1); meas_req_i = 0; wait_n(2);
    low_pulse(300); wait_n(2);
    chk("R8 width saturates", width_o, MAXW);
    chk("R8 valid after saturated capture", width_valid_o, 1);

    wait_n(5);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule